// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block turns requests from a simple on-chip port into command sequences on the pins of a DDR SDRAM device. The requester presents a three-bit request code, a 23-bit address, an auto-precharge flag and a 16-bit write word. It does so while `req_ready` is high. The block drives clock enable, chip select, row strobe, column strobe and write enable. It also drives the bank and multiplexed address lines, plus the read and write enables that gate the separate dual-edge data path.

Every read or write first opens its row with an ACTIVE command. The column command follows in the next cycle. A read then waits out a counted CAS latency and holds the read enable for one clock per 16-bit word, which is two beats of an 8-bit bus. A terminate input can cut a read short with a BURST TERMINATE. Burst length and CAS latency come from the last mode-register load. The block also produces the memory clock at half the system rate, together with its inverse.

Top module: `ddr_cmd_ctrl`

## Requirements
- R1: Right after reset, `req_ready` is 1, the pins {cs_n,ras_n,cas_n,we_n} show NOP (0111), both data enables are 0 and `ddr_cke` is 1.
- R2: Command codes on {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, BURST TERMINATE 0110, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R3: The address splits into bank = addr[22:21], row = addr[20:9] and column = addr[8:0]. ACTIVE drives the bank and the row. READ and WRITE drive the bank, the column on a[8:0], the auto-precharge flag on a[10], and 0 on a[9] and a[11].
- R4: Request code 1 (read) gives ACTIVE, then READ in the next cycle, then CL cycles of NOP with the read enable low. Then come W cycles with the read enable high, where W = burst length / 2. Then `req_ready` returns.
- R5: Request code 2 (write) gives ACTIVE, then WRITE, then W cycles with the write enable high and `dp_wdata` equal to the accepted write word. Then `req_ready` returns.
- R6: When `req_term` is high in a read-data cycle, the next cycle shows BURST TERMINATE with the read enable low, and the cycle after that is idle. This holds even on the last data cycle.
- R7: `req_term` has no effect outside the read-data cycles.
- R8: Request code 5 drives LOAD MODE with ba = addr[22:21] and a = addr[11:0]. Field a[2:0] = 1, 2 or 3 selects a burst length of 2, 4 or 8. Field a[6:4] = 2 or 3 selects the CAS latency. Any other field value leaves that setting unchanged. After reset the burst length is 2 and the CAS latency is 2.
- R9: Request code 4 drives PRECHARGE with a[10] = 1 (all banks), then NOP. The precharge occupies TRP_CYC cycles (default 3) before `req_ready` returns.
- R10: Request code 3 drives a single AUTO REFRESH cycle, then returns to idle.
- R11: `req_ready` is low from the cycle after acceptance until the sequence is back in idle. Requests made while busy are ignored. Request codes 0, 6 and 7 are ignored and `req_ready` stays 1.
- R12: `ddr_clk` toggles on every system clock edge, and `ddr_clk_n` is always its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 3 | Request code (1 read, 2 write, 3 refresh, 4 precharge, 5 mode load) |
| req_addr | input | 23 | System address {bank,row,column} or mode value |
| req_auto_pre | input | 1 | Auto-precharge request for read/write |
| req_wdata | input | 16 | Write word |
| req_term | input | 1 | Terminate the running read burst |
| req_ready | output | 1 | Idle and able to accept a request |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select |
| ddr_ras_n | output | 1 | Row strobe |
| ddr_cas_n | output | 1 | Column strobe |
| ddr_we_n | output | 1 | Write enable |
| ddr_ba | output | 2 | Bank address |
| ddr_a | output | 12 | Row/column/mode address |
| dp_rd_en | output | 1 | Read capture enable for the data path |
| dp_wr_en | output | 1 | Write drive enable for the data path |
| dp_wdata | output | 16 | Write word for the data path |
| ddr_clk | output | 1 | Memory clock, half the system rate |
| ddr_clk_n | output | 1 | Inverted memory clock |

## Verification
The hardest case to reach is a terminate that lands on the last read-data cycle at the longest burst and latency. This needs a mode load of burst 8 and CAS latency 3 first, and then a terminate timed to one exact cycle. The directed part of the stimulus covers it and the first-cycle terminate. The random part mixes mode loads carrying valid and invalid field values with reads, writes, precharges and refreshes. It also sets terminate pulses during the CAS-latency wait and request pulses while the block is busy. These show that the ignored inputs leave the timing unchanged.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    // Request codes on the internal port
    localparam logic [2:0] REQ_READ      = 3'd1;
    localparam logic [2:0] REQ_WRITE     = 3'd2;
    localparam logic [2:0] REQ_REFRESH   = 3'd3;
    localparam logic [2:0] REQ_PRECHARGE = 3'd4;
    localparam logic [2:0] REQ_LOAD_MR   = 3'd5;

    // Address line that carries auto-precharge / all-bank precharge
    localparam int AP_BIT = 10;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRECHARGE,
        S_AUTO_RFS,
        S_LOAD_MR,
        S_ACTIVE,
        S_READ,
        S_WRITE,
        S_CAS_LAT,
        S_RD_DATA,
        S_WR_DATA,
        S_BRST_TERM
    } seq_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        PIN_LMR = 4'b0000,
        PIN_REF = 4'b0001,
        PIN_PRE = 4'b0010,
        PIN_ACT = 4'b0011,
        PIN_WR  = 4'b0100,
        PIN_RD  = 4'b0101,
        PIN_BST = 4'b0110,
        PIN_NOP = 4'b0111
    } pin_cmd_e;

endpackage

// File: rtl/ddr_addr_split.sv
module ddr_addr_split #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);

    // bank occupies the top bits, then row, then column
    assign bank = addr[ADDR_W-1 -: BANK_W];
    assign row  = addr[COL_W +: ROW_W];
    assign col  = addr[COL_W-1:0];

endmodule

// File: rtl/ddr_pin_encoder.sv
module ddr_pin_encoder
    import ddr_cmd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9
) (
    input  seq_state_e        state,
    input  logic              first,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic              ap,
    input  logic [ROW_W-1:0]  mr_val,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  a
);

    pin_cmd_e pcmd;
    logic [ROW_W-1:0] col_word;

    always_comb begin
        col_word = '0;
        col_word[COL_W-1:0] = col;
        col_word[AP_BIT] = ap;
    end

    always_comb begin
        pcmd = PIN_NOP;
        ba   = '0;
        a    = '0;
        case (state)
            S_PRECHARGE: begin
                if (first) begin
                    pcmd = PIN_PRE;
                    a[AP_BIT] = 1'b1;
                end
            end
            S_AUTO_RFS:  pcmd = PIN_REF;
            S_LOAD_MR: begin
                pcmd = PIN_LMR;
                ba   = bank;
                a    = mr_val;
            end
            S_ACTIVE: begin
                pcmd = PIN_ACT;
                ba   = bank;
                a    = row;
            end
            S_READ: begin
                pcmd = PIN_RD;
                ba   = bank;
                a    = col_word;
            end
            S_WRITE: begin
                pcmd = PIN_WR;
                ba   = bank;
                a    = col_word;
            end
            S_BRST_TERM: pcmd = PIN_BST;
            default:     pcmd = PIN_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = pcmd;

endmodule

// File: rtl/ddr_mem_clkgen.sv
module ddr_mem_clkgen (
    input  logic clk,
    input  logic rst_n,
    output logic mclk,
    output logic mclk_n
);

    logic ph_d, ph_q;

    always_comb ph_d = ~ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ph_d;
    end

    assign mclk   = ph_q;
    assign mclk_n = ~ph_q;

endmodule

// File: rtl/ddr_cmd_ctrl.sv
module ddr_cmd_ctrl
    import ddr_cmd_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 9,
    parameter int DATA_W  = 16,
    parameter int TRP_CYC = 3,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int CNT_W  = $clog2(TRP_CYC + 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_auto_pre,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_term,
    output logic              req_ready,
    output logic              ddr_cke,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BANK_W-1:0] ddr_ba,
    output logic [ROW_W-1:0]  ddr_a,
    output logic              dp_rd_en,
    output logic              dp_wr_en,
    output logic [DATA_W-1:0] dp_wdata,
    output logic              ddr_clk,
    output logic              ddr_clk_n
);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              ap;
        logic              op_wr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        bl_code;
        logic [2:0]        cl;
        logic              cke;
    } regs_t;

    regs_t r_d, r_q;

    logic [CNT_W-1:0]  words_m1;
    logic [CNT_W-1:0]  cl_m1;
    logic [BANK_W-1:0] f_bank;
    logic [ROW_W-1:0]  f_row;
    logic [COL_W-1:0]  f_col;

    // data cycles per burst minus one: burst 2/4/8 -> 1/2/4 words
    always_comb begin
        case (r_q.bl_code)
            2'd2:    words_m1 = CNT_W'(1);
            2'd3:    words_m1 = CNT_W'(3);
            default: words_m1 = '0;
        endcase
    end

    assign cl_m1 = CNT_W'(r_q.cl) - CNT_W'(1);

    always_comb begin
        r_d     = r_q;
        r_d.cke = 1'b1;
        case (r_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.ap    = req_auto_pre;
                    r_d.wdata = req_wdata;
                    r_d.cnt   = '0;
                    case (req_cmd)
                        REQ_READ: begin
                            r_d.state = S_ACTIVE;
                            r_d.op_wr = 1'b0;
                        end
                        REQ_WRITE: begin
                            r_d.state = S_ACTIVE;
                            r_d.op_wr = 1'b1;
                        end
                        REQ_REFRESH:   r_d.state = S_AUTO_RFS;
                        REQ_PRECHARGE: r_d.state = S_PRECHARGE;
                        REQ_LOAD_MR:   r_d.state = S_LOAD_MR;
                        default:       r_d.state = S_IDLE;
                    endcase
                end
            end
            S_ACTIVE: r_d.state = r_q.op_wr ? S_WRITE : S_READ;
            S_READ: begin
                r_d.state = S_CAS_LAT;
                r_d.cnt   = '0;
            end
            S_WRITE: begin
                r_d.state = S_WR_DATA;
                r_d.cnt   = '0;
            end
            S_CAS_LAT: begin
                if (r_q.cnt < cl_m1) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end else begin
                    r_d.state = S_RD_DATA;
                    r_d.cnt   = '0;
                end
            end
            S_RD_DATA: begin
                if (req_term)                r_d.state = S_BRST_TERM;
                else if (r_q.cnt < words_m1) r_d.cnt = r_q.cnt + 1'b1;
                else                         r_d.state = S_IDLE;
            end
            S_WR_DATA: begin
                if (r_q.cnt < words_m1) r_d.cnt = r_q.cnt + 1'b1;
                else                    r_d.state = S_IDLE;
            end
            S_PRECHARGE: begin
                if (r_q.cnt < CNT_W'(TRP_CYC - 1)) r_d.cnt = r_q.cnt + 1'b1;
                else                               r_d.state = S_IDLE;
            end
            S_LOAD_MR: begin
                r_d.state = S_IDLE;
                if (r_q.addr[2:0] inside {3'd1, 3'd2, 3'd3})
                    r_d.bl_code = r_q.addr[1:0];
                if (r_q.addr[6:4] inside {3'd2, 3'd3})
                    r_d.cl = r_q.addr[6:4];
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= S_IDLE;
            r_q.bl_code <= 2'd1;
            r_q.cl      <= 3'd2;
        end else begin
            r_q <= r_d;
        end
    end

    ddr_addr_split #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_split (
        .addr(r_q.addr),
        .bank(f_bank),
        .row (f_row),
        .col (f_col)
    );

    ddr_pin_encoder #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_enc (
        .state (r_q.state),
        .first (r_q.cnt == '0),
        .bank  (f_bank),
        .row   (f_row),
        .col   (f_col),
        .ap    (r_q.ap),
        .mr_val(r_q.addr[ROW_W-1:0]),
        .cs_n  (ddr_cs_n),
        .ras_n (ddr_ras_n),
        .cas_n (ddr_cas_n),
        .we_n  (ddr_we_n),
        .ba    (ddr_ba),
        .a     (ddr_a)
    );

    ddr_mem_clkgen u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .mclk  (ddr_clk),
        .mclk_n(ddr_clk_n)
    );

    assign req_ready = (r_q.state == S_IDLE);
    assign dp_rd_en  = (r_q.state == S_RD_DATA);
    assign dp_wr_en  = (r_q.state == S_WR_DATA);
    assign dp_wdata  = r_q.wdata;
    assign ddr_cke   = r_q.cke;

endmodule

// File: rtl/ddr_cmd_ctrl_chk.sv
module ddr_cmd_ctrl_chk #(
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             ddr_cke,
    input logic             ddr_cs_n,
    input logic             ddr_ras_n,
    input logic             ddr_cas_n,
    input logic             ddr_we_n,
    input logic [ROW_W-1:0] ddr_a,
    input logic             dp_rd_en,
    input logic             dp_wr_en,
    input logic             ddr_clk
);

    logic [3:0] pins;
    assign pins = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};

    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (pins == 4'b0111 && !dp_rd_en && !dp_wr_en));

    p_act_then_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pins == 4'b0011 |=> (pins == 4'b0101 || pins == 4'b0100));

    p_rd_data_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rd_en |-> pins == 4'b0111);

    p_rw_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_rd_en && dp_wr_en));

    p_bst_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pins == 4'b0110 |-> $past(dp_rd_en));

    p_bst_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pins == 4'b0110 |=> req_ready);

    p_pre_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pins == 4'b0010 |-> ddr_a[10]);

    p_cke_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |=> ddr_cke);

    p_clk_toggle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ddr_clk != $past(ddr_clk));

endmodule

bind ddr_cmd_ctrl ddr_cmd_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .ddr_cke  (ddr_cke),
    .ddr_cs_n (ddr_cs_n),
    .ddr_ras_n(ddr_ras_n),
    .ddr_cas_n(ddr_cas_n),
    .ddr_we_n (ddr_we_n),
    .ddr_a    (ddr_a),
    .dp_rd_en (dp_rd_en),
    .dp_wr_en (dp_wr_en),
    .ddr_clk  (ddr_clk)
);

// File: tb/ddr_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module ddr_cmd_ctrl_tb;

    localparam int TRP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = '0;
    logic [22:0] req_addr = '0;
    logic        req_auto_pre = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_term = 1'b0;
    logic        req_ready, ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [1:0]  ddr_ba;
    logic [11:0] ddr_a;
    logic        dp_rd_en, dp_wr_en, ddr_clk, ddr_clk_n;
    logic [15:0] dp_wdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    int m_bl = 2;
    int m_cl = 2;

    always #2.5 clk = ~clk;

    ddr_cmd_ctrl #(.TRP_CYC(TRP)) u_dut (.*);

    function automatic logic [3:0] pins();
        return {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
    endfunction

    function automatic logic [11:0] col_word(input logic [22:0] ad, input logic ap);
        return {1'b0, ap, 1'b0, ad[8:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_pins(input logic [3:0] exp, input string req);
        chk(pins() == exp, req, pins(), exp);
    endtask

    task automatic chk_clk();
        logic prev;
        prev = ddr_clk;
        @(negedge clk);
        chk(ddr_clk == ~prev && ddr_clk_n == ~ddr_clk, "R12 clock toggle", {ddr_clk, ddr_clk_n}, {~prev, prev});
    endtask

    task automatic accept(input logic [2:0] c, input logic [22:0] ad, input logic ap, input logic [15:0] wd);
        req_valid = 1'b1; req_cmd = c; req_addr = ad; req_auto_pre = ap; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11 busy after accept", req_ready, 0);
    endtask

    task automatic do_read(input logic [22:0] ad, input logic ap, input int term_at, input bit cas_noise);
        bit ended;
        accept(3'd1, ad, ap, 16'h0);
        chk_pins(4'b0011, "R2 R4 ACTIVE");
        chk({ddr_ba, ddr_a} == {ad[22:21], ad[20:9]}, "R3 bank/row", {ddr_ba, ddr_a}, {ad[22:21], ad[20:9]});
        @(negedge clk);
        chk_pins(4'b0101, "R2 R4 READ");
        chk({ddr_ba, ddr_a} == {ad[22:21], col_word(ad, ap)}, "R3 bank/col/ap", {ddr_ba, ddr_a}, {ad[22:21], col_word(ad, ap)});
        for (int c = 0; c < m_cl; c++) begin
            @(negedge clk);
            req_term = cas_noise ? 1'($urandom_range(0, 1)) : 1'b0;
            chk(pins() == 4'b0111 && !dp_rd_en, "R4 R7 CAS wait", {pins(), dp_rd_en}, 5'b01110);
        end
        ended = 0;
        for (int i = 0; i < m_bl / 2; i++) begin
            @(negedge clk);
            req_term = 1'b0;
            chk(dp_rd_en && pins() == 4'b0111 && !req_ready, "R4 read data", {dp_rd_en, pins()}, 5'b10111);
            if (i == term_at) begin
                req_term = 1'b1;
                @(negedge clk);
                req_term = 1'b0;
                chk(pins() == 4'b0110 && !dp_rd_en, "R6 burst terminate", {pins(), dp_rd_en}, 5'b01100);
                ended = 1;
                break;
            end
        end
        @(negedge clk);
        chk(req_ready && pins() == 4'b0111, "R4 R6 back to idle", {req_ready, pins()}, 5'b10111);
    endtask

    task automatic do_write(input logic [22:0] ad, input logic ap, input logic [15:0] wd, input bit poke);
        accept(3'd2, ad, ap, wd);
        chk_pins(4'b0011, "R2 R5 ACTIVE");
        chk({ddr_ba, ddr_a} == {ad[22:21], ad[20:9]}, "R3 bank/row", {ddr_ba, ddr_a}, {ad[22:21], ad[20:9]});
        @(negedge clk);
        chk_pins(4'b0100, "R2 R5 WRITE");
        chk({ddr_ba, ddr_a} == {ad[22:21], col_word(ad, ap)}, "R3 bank/col/ap", {ddr_ba, ddr_a}, {ad[22:21], col_word(ad, ap)});
        if (poke) begin
            req_valid = 1'b1; req_cmd = 3'd3;
        end
        for (int i = 0; i < m_bl / 2; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk(dp_wr_en && pins() == 4'b0111 && dp_wdata == wd, "R5 R11 write data", {dp_wr_en, pins(), dp_wdata}, {1'b1, 4'b0111, wd});
        end
        @(negedge clk);
        chk(req_ready && !dp_wr_en, "R5 back to idle", {req_ready, dp_wr_en}, 2'b10);
    endtask

    task automatic do_lmr(input logic [22:0] ad);
        accept(3'd5, ad, 1'b0, 16'h0);
        chk(pins() == 4'b0000 && ddr_ba == ad[22:21] && ddr_a == ad[11:0], "R8 LOAD MODE", {pins(), ddr_ba, ddr_a}, {4'b0000, ad[22:21], ad[11:0]});
        if (ad[2:0] inside {3'd1, 3'd2, 3'd3}) m_bl = 2 << (ad[2:0] - 1);
        if (ad[6:4] inside {3'd2, 3'd3}) m_cl = int'(ad[6:4]);
        @(negedge clk);
        chk(req_ready, "R8 idle after mode load", req_ready, 1);
    endtask

    task automatic do_pre();
        accept(3'd4, 23'($urandom), 1'b0, 16'h0);
        chk(pins() == 4'b0010 && ddr_a[10], "R9 PRECHARGE all", {pins(), ddr_a[10]}, 5'b00101);
        for (int k = 1; k < TRP; k++) begin
            @(negedge clk);
            chk(pins() == 4'b0111 && !req_ready, "R9 tRP wait", {pins(), req_ready}, 5'b01110);
        end
        @(negedge clk);
        chk(req_ready, "R9 ready after tRP", req_ready, 1);
    endtask

    task automatic do_ref();
        accept(3'd3, 23'($urandom), 1'b0, 16'h0);
        chk_pins(4'b0001, "R10 AUTO REFRESH");
        @(negedge clk);
        chk(req_ready && pins() == 4'b0111, "R10 single cycle", {req_ready, pins()}, 5'b10111);
    endtask

    task automatic do_invalid(input logic [2:0] c);
        req_valid = 1'b1; req_cmd = c;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready && pins() == 4'b0111, "R11 invalid code ignored", {req_ready, pins()}, 5'b10111);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && pins() == 4'b0111 && !dp_rd_en && !dp_wr_en && ddr_cke,
            "R1 reset state", {req_ready, pins(), dp_rd_en, dp_wr_en, ddr_cke}, 8'b10111001);
        chk_clk();
        chk_clk();

        // directed corners
        do_read(23'h5A_1234, 1'b0, -1, 1'b0);
        do_write(23'h2B_0F0F, 1'b1, 16'hBEEF, 1'b1);
        do_lmr(23'h000033);
        do_read(23'h7F_FFFF, 1'b1, 0, 1'b1);
        do_read(23'h40_0101, 1'b0, 3, 1'b0);
        do_lmr(23'h000077);
        do_read(23'h12_3456, 1'b0, -1, 1'b0);
        do_write(23'h00_0000, 1'b0, 16'h1234, 1'b0);
        do_pre();
        do_ref();
        do_invalid(3'd6);
        do_invalid(3'd0);
        do_invalid(3'd7);
        chk_clk();

        // random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            op = $urandom_range(0, 6);
            case (op)
                0, 1: do_read(23'($urandom), 1'($urandom), $urandom_range(0, 5) == 0 ? -1 : $urandom_range(0, 3), 1'($urandom));
                2:    do_write(23'($urandom), 1'($urandom), 16'($urandom), 1'($urandom));
                3:    do_lmr({16'($urandom), 1'b0, 2'($urandom_range(1, 3)), 1'($urandom), 3'($urandom)});
                4:    do_pre();
                5:    do_ref();
                default: do_invalid($urandom_range(0, 1) == 0 ? 3'd6 : 3'd7);
            endcase
            if (n % 50 == 0) chk_clk();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule